// File: doc/BRIEF.md
# Keyed Configuration Window for an ATA Command Port

This block sits between a host register bus and the drive registers behind the byte-addressed command port of an ATA channel. Normally every access goes straight through to the drive registers. A key hidden in ordinary traffic switches the port into a configuration mode. The key is two 16-bit reads at offset 1 followed by an 8-bit write of 0x03 at offset 2. In that mode the drive registers disappear and a handful of offsets address internal timing, control, strap and miscellaneous registers instead.

Timing is kept in two banks, one per attached device. A select bit in the miscellaneous register picks the bank that the read-timing and write-timing offsets reach. The same register also holds a shared address-setup field. Programmed values reach the exported timing outputs only when software writes the commit code to the control register. An 8-bit write of 0x83 to offset 2 closes the window and returns the port to drive mode.

Top module: `ata_keyed_cfg_port`

## Requirements
- R1: After reset the port is in drive mode, the key tracker is idle, the miscellaneous register holds 0x30, the control register holds 0, and every bank and every exported timing is 0xFF with the exported address setup at 3.
- R2: In drive mode, a 16-bit read at offset 1, another 16-bit read at offset 1 and then an 8-bit write (busWide=0) of 0x03 at offset 2, with no other access between them, set cfgMode on the following clock edge. That final write is not passed to the drive.
- R3: Any access in drive mode other than a 16-bit read at offset 1 returns the key tracker to idle, so a later 0x03 write passes through as a normal drive write. More than two consecutive qualifying reads keep the key armed. Idle cycles with no strobe do not disturb the tracker.
- R4: In drive mode, drvRd and drvWr follow busRd and busWr in the same cycle (except for the write that completes the key). busRdata equals drvRdata, and drvWdata equals busWdata whenever drvWr is high and is 0 otherwise.
- R5: In configuration mode drvRd, drvWr and drvWdata stay low for every access.
- R6: In configuration mode reads return zero-extended bytes as follows: offset 3 gives the control register, offset 5 gives bit 0 equal to the live strap pin (0 = 33 MHz, 1 = 25 MHz), offset 6 gives the miscellaneous register, and offsets 2, 4 and 7 give 0. Writes take the low data byte. Offsets 5, 4 and 7 ignore writes.
- R7: Offset 0 (read timing) and offset 1 (write timing) reach the bank chosen by bit 0 of the miscellaneous register, for both writes and reads.
- R8: In configuration mode an 8-bit write of 0x83 at offset 2 clears cfgMode on the following edge. Any other write at offset 2 has no effect.
- R9: A configuration-mode write of 0x85 at offset 3 copies bank 0 and bank 1 to the exported read and write timings and copies bits 7:4 of the miscellaneous register to setupOut, visible after the next edge. Without that write the exported values hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset of the host access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| busWdata | input | 16 | Host write data |
| busRdata | output | 16 | Host read data, same cycle as busRd |
| drvRd | output | 1 | Read strobe forwarded to drive registers |
| drvWr | output | 1 | Write strobe forwarded to drive registers |
| drvWdata | output | 16 | Write data forwarded to drive registers |
| drvRdata | input | 16 | Read data from drive registers |
| strapClk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| cfgMode | output | 1 | High while the configuration window is open |
| rdTiming | output | 16 | Committed read timing, bank b at bits [8b+7:8b] |
| wrTiming | output | 16 | Committed write timing, bank b at bits [8b+7:8b] |
| setupOut | output | 4 | Committed shared address-setup field |

## Verification
The forwarded strobes, the forwarded write data and busRdata are combinational, so they are due in the same cycle as the access. Mode changes, register writes and the committed timing outputs appear one rising edge after the access. The bench drives each access just after a falling edge and samples the combinational results 1 ns later, before the next rising edge. It samples the registered results at the sample point of the following access, when exactly one edge has passed.

// File: rtl/keycfg_pkg.sv
package keycfg_pkg;

  localparam int unsigned OFF_W  = 3;
  localparam int unsigned BYTE_W = 8;

  // offsets decoded inside the window
  localparam logic [OFF_W-1:0] OFF_RDTIME = 3'd0;
  localparam logic [OFF_W-1:0] OFF_WRTIME = 3'd1;
  localparam logic [OFF_W-1:0] OFF_LOCK   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_STRAP  = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MISC   = 3'd6;
  // offset of the word reads that arm the key
  localparam logic [OFF_W-1:0] OFF_KEYRD  = 3'd1;

  localparam logic [BYTE_W-1:0] KEY_CODE    = 8'h03;
  localparam logic [BYTE_W-1:0] RELOCK_CODE = 8'h83;
  localparam logic [BYTE_W-1:0] COMMIT_CODE = 8'h85;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_ONE  = 2'd1,
    KEY_TWO  = 2'd2
  } keyState_t;

  typedef struct packed {
    logic cfgMode;
    logic wrRdTime;
    logic wrWrTime;
    logic wrCtrl;
    logic wrMisc;
    logic commit;
  } cfgStrobe_t;

endpackage

// File: rtl/keycfg_ctrl.sv
module keycfg_ctrl
  import keycfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OFF_W-1:0]     busAddr,
  input  logic                 busRd,
  input  logic                 busWr,
  input  logic                 busWide,
  input  logic [BYTE_W-1:0]    wByte,
  output cfgStrobe_t           stb,
  output logic                 drvRd,
  output logic                 drvWr
);

  keyState_t keyState, keyNext;
  logic      modeQ, modeNext;
  logic      anyAccess, keyRead, unlockHit, relockHit, cfgWr;

  assign anyAccess = busRd | busWr;
  assign keyRead   = busRd & busWide & (busAddr == OFF_KEYRD);
  assign unlockHit = ~modeQ & (keyState == KEY_TWO) & busWr & ~busWide &
                     (busAddr == OFF_LOCK) & (wByte == KEY_CODE);
  assign relockHit = modeQ & busWr & ~busWide &
                     (busAddr == OFF_LOCK) & (wByte == RELOCK_CODE);
  assign cfgWr     = modeQ & busWr;

  always_comb begin
    keyNext = keyState;
    if (modeQ || unlockHit) begin
      keyNext = KEY_IDLE;
    end else if (anyAccess) begin
      if (keyRead) begin
        unique case (keyState)
          KEY_IDLE: keyNext = KEY_ONE;
          KEY_ONE:  keyNext = KEY_TWO;
          default:  keyNext = KEY_TWO;
        endcase
      end else begin
        keyNext = KEY_IDLE;
      end
    end
  end

  always_comb begin
    modeNext = modeQ;
    if (unlockHit)      modeNext = 1'b1;
    else if (relockHit) modeNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyState <= KEY_IDLE;
      modeQ    <= 1'b0;
    end else begin
      keyState <= keyNext;
      modeQ    <= modeNext;
    end
  end

  assign drvRd = busRd & ~modeQ;
  assign drvWr = busWr & ~modeQ & ~unlockHit;

  always_comb begin
    stb          = '0;
    stb.cfgMode  = modeQ;
    stb.wrRdTime = cfgWr & (busAddr == OFF_RDTIME);
    stb.wrWrTime = cfgWr & (busAddr == OFF_WRTIME);
    stb.wrCtrl   = cfgWr & (busAddr == OFF_CTRL);
    stb.wrMisc   = cfgWr & (busAddr == OFF_MISC);
    stb.commit   = cfgWr & (busAddr == OFF_CTRL) & (wByte == COMMIT_CODE);
  end

endmodule

// File: rtl/keycfg_regs.sv
module keycfg_regs
  import keycfg_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TIME_W   = 8,
  parameter int unsigned SETUP_W  = 4,
  parameter int unsigned NUM_BANK = 2,
  parameter logic [TIME_W-1:0]  TIME_RST  = '1,
  parameter logic [SETUP_W-1:0] SETUP_RST = 4'd3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobe_t                 stb,
  input  logic [OFF_W-1:0]           busAddr,
  input  logic [BYTE_W-1:0]          wByte,
  input  logic [DATA_W-1:0]          drvRdata,
  input  logic                       strapClk25,
  output logic [DATA_W-1:0]          busRdata,
  output logic [NUM_BANK*TIME_W-1:0] rdTiming,
  output logic [NUM_BANK*TIME_W-1:0] wrTiming,
  output logic [SETUP_W-1:0]         setupOut
);

  localparam int unsigned SEL_W     = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
  localparam int unsigned SETUP_LSB = BYTE_W - SETUP_W;
  localparam logic [BYTE_W-1:0] MISC_RST = BYTE_W'({SETUP_RST, {SETUP_LSB{1'b0}}});

  logic [BYTE_W-1:0] miscReg, ctrlReg;
  logic [TIME_W-1:0] rdBank [NUM_BANK];
  logic [TIME_W-1:0] wrBank [NUM_BANK];
  logic [SEL_W-1:0]  selBank;

  assign selBank = miscReg[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      miscReg  <= MISC_RST;
      ctrlReg  <= '0;
      setupOut <= SETUP_RST;
    end else begin
      if (stb.wrMisc) miscReg <= wByte;
      if (stb.wrCtrl) ctrlReg <= wByte;
      if (stb.commit) setupOut <= miscReg[BYTE_W-1:SETUP_LSB];
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdBank[b]                   <= TIME_RST;
        wrBank[b]                   <= TIME_RST;
        rdTiming[b*TIME_W +: TIME_W] <= TIME_RST;
        wrTiming[b*TIME_W +: TIME_W] <= TIME_RST;
      end else begin
        if (stb.wrRdTime && selBank == SEL_W'(b)) rdBank[b] <= wByte[TIME_W-1:0];
        if (stb.wrWrTime && selBank == SEL_W'(b)) wrBank[b] <= wByte[TIME_W-1:0];
        if (stb.commit) begin
          rdTiming[b*TIME_W +: TIME_W] <= rdBank[b];
          wrTiming[b*TIME_W +: TIME_W] <= wrBank[b];
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (!stb.cfgMode) begin
      busRdata = drvRdata;
    end else begin
      unique case (busAddr)
        OFF_RDTIME: busRdata[TIME_W-1:0] = rdBank[selBank];
        OFF_WRTIME: busRdata[TIME_W-1:0] = wrBank[selBank];
        OFF_CTRL:   busRdata[BYTE_W-1:0] = ctrlReg;
        OFF_STRAP:  busRdata[0]          = strapClk25;
        OFF_MISC:   busRdata[BYTE_W-1:0] = miscReg;
        default:    busRdata             = '0;
      endcase
    end
  end

endmodule

// File: rtl/ata_keyed_cfg_port.sv
module ata_keyed_cfg_port
  import keycfg_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TIME_W  = 8,
  parameter int unsigned SETUP_W = 4,
  parameter logic [TIME_W-1:0]  TIME_RST  = '1,
  parameter logic [SETUP_W-1:0] SETUP_RST = 4'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busWide,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              drvRd,
  output logic              drvWr,
  output logic [DATA_W-1:0] drvWdata,
  input  logic [DATA_W-1:0] drvRdata,
  input  logic              strapClk25,
  output logic              cfgMode,
  output logic [2*TIME_W-1:0] rdTiming,
  output logic [2*TIME_W-1:0] wrTiming,
  output logic [SETUP_W-1:0]  setupOut
);

  localparam int unsigned NUM_BANK = 2;

  cfgStrobe_t        stb;
  logic [BYTE_W-1:0] wByte;

  assign wByte    = busWdata[BYTE_W-1:0];
  assign cfgMode  = stb.cfgMode;
  assign drvWdata = drvWr ? busWdata : '0;

  keycfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busWide (busWide),
    .wByte   (wByte),
    .stb     (stb),
    .drvRd   (drvRd),
    .drvWr   (drvWr)
  );

  keycfg_regs #(
    .DATA_W    (DATA_W),
    .TIME_W    (TIME_W),
    .SETUP_W   (SETUP_W),
    .NUM_BANK  (NUM_BANK),
    .TIME_RST  (TIME_RST),
    .SETUP_RST (SETUP_RST)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busAddr    (busAddr),
    .wByte      (wByte),
    .drvRdata   (drvRdata),
    .strapClk25 (strapClk25),
    .busRdata   (busRdata),
    .rdTiming   (rdTiming),
    .wrTiming   (wrTiming),
    .setupOut   (setupOut)
  );

endmodule

// File: rtl/keycfg_chk.sv
module keycfg_chk
  import keycfg_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TIME_W  = 8,
  parameter int unsigned SETUP_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          busAddr,
  input logic                busRd,
  input logic                busWr,
  input logic                busWide,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic                drvRd,
  input logic                drvWr,
  input logic [DATA_W-1:0]   drvWdata,
  input logic [DATA_W-1:0]   drvRdata,
  input logic                strapClk25,
  input logic                cfgMode,
  input logic [2*TIME_W-1:0] rdTiming,
  input logic [2*TIME_W-1:0] wrTiming,
  input logic [SETUP_W-1:0]  setupOut
);

  // R5
  hide_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode |-> (!drvRd && !drvWr && drvWdata == '0));

  // R8
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && busWr && !busWide && busAddr == OFF_LOCK &&
     busWdata[7:0] == RELOCK_CODE) |=> !cfgMode);

  // R2
  unlock_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgMode) |-> $past(busWr && !busWide && busAddr == OFF_LOCK &&
                             busWdata[7:0] == KEY_CODE));

  // R9
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgMode && busWr && busAddr == OFF_CTRL && busWdata[7:0] == COMMIT_CODE)
    |=> ($stable(rdTiming) && $stable(wrTiming) && $stable(setupOut)));

  // R6
  strap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && busRd && busAddr == OFF_STRAP) |-> busRdata[0] == strapClk25);

  // R4
  pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode && busRd) |-> (drvRd && busRdata == drvRdata));

endmodule

bind ata_keyed_cfg_port keycfg_chk #(
  .DATA_W (DATA_W),
  .TIME_W (TIME_W),
  .SETUP_W(SETUP_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busRd      (busRd),
  .busWr      (busWr),
  .busWide    (busWide),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .drvRd      (drvRd),
  .drvWr      (drvWr),
  .drvWdata   (drvWdata),
  .drvRdata   (drvRdata),
  .strapClk25 (strapClk25),
  .cfgMode    (cfgMode),
  .rdTiming   (rdTiming),
  .wrTiming   (wrTiming),
  .setupOut   (setupOut)
);

// File: tb/sim_ata_keyed_cfg_port.sv
`timescale 1ns/1ps
module sim_ata_keyed_cfg_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0, busWide = 1'b0;
  logic [15:0] busWdata = '0, busRdata, drvWdata, drvRdata = '0;
  logic        drvRd, drvWr, strapClk25 = 1'b0, cfgMode;
  logic [15:0] rdTiming, wrTiming;
  logic [3:0]  setupOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit        mMode;
  int        mKey;
  bit [7:0]  mRd [2];
  bit [7:0]  mWr [2];
  bit [7:0]  mMisc, mCtrl;
  bit [15:0] oRd, oWr;
  bit [3:0]  oSetup;

  always #2 clk = ~clk;

  ata_keyed_cfg_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWide(busWide), .busWdata(busWdata), .busRdata(busRdata),
    .drvRd(drvRd), .drvWr(drvWr), .drvWdata(drvWdata), .drvRdata(drvRdata),
    .strapClk25(strapClk25), .cfgMode(cfgMode), .rdTiming(rdTiming),
    .wrTiming(wrTiming), .setupOut(setupOut)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit [15:0] cfgRead(input bit [2:0] a);
    case (a)
      3'd0: return {8'h00, mRd[mMisc[0]]};
      3'd1: return {8'h00, mWr[mMisc[0]]};
      3'd3: return {8'h00, mCtrl};
      3'd5: return {15'h0, strapClk25};
      3'd6: return {8'h00, mMisc};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic resetModel();
    mMode = 0; mKey = 0; mMisc = 8'h30; mCtrl = 8'h00;
    for (int b = 0; b < 2; b++) begin mRd[b] = 8'hFF; mWr[b] = 8'hFF; end
    oRd = 16'hFFFF; oWr = 16'hFFFF; oSetup = 4'd3;
  endtask

  task automatic checkState(input string tag);
    chk(cfgMode == mMode, mMode ? "R2" : tag, "cfgMode", 32'(cfgMode), 32'(mMode));
    chk(rdTiming == oRd, "R9", "rdTiming", 32'(rdTiming), 32'(oRd));
    chk(wrTiming == oWr, "R9", "wrTiming", 32'(wrTiming), 32'(oWr));
    chk(setupOut == oSetup, "R9", "setupOut", 32'(setupOut), 32'(oSetup));
  endtask

  task automatic op(input bit rd, input bit wr, input bit wide,
                    input bit [2:0] a, input bit [15:0] d, input string tag);
    bit unl, expDrvWr;
    bit [15:0] expR;
    @(negedge clk);
    busRd = rd; busWr = wr; busWide = wide; busAddr = a; busWdata = d;
    drvRdata = 16'($urandom);
    #1;
    checkState(tag);
    unl = !mMode && mKey == 2 && wr && !wide && a == 3'd2 && d[7:0] == 8'h03;
    expDrvWr = wr && !mMode && !unl;
    chk(drvRd == (rd && !mMode), mMode ? "R5" : "R4", "drvRd", 32'(drvRd), 32'(rd && !mMode));
    chk(drvWr == expDrvWr, mMode ? "R5" : (unl ? "R2" : "R4"), "drvWr", 32'(drvWr), 32'(expDrvWr));
    chk(drvWdata == (expDrvWr ? d : 16'h0), mMode ? "R5" : "R4", "drvWdata",
        32'(drvWdata), 32'(expDrvWr ? d : 16'h0));
    if (rd) begin
      expR = mMode ? cfgRead(a) : drvRdata;
      chk(busRdata == expR, mMode ? ((a < 3'd2) ? "R7" : "R6") : "R4", "busRdata",
          32'(busRdata), 32'(expR));
    end
    // model update
    if (mMode) begin
      if (wr) begin
        case (a)
          3'd0: mRd[mMisc[0]] = d[7:0];
          3'd1: mWr[mMisc[0]] = d[7:0];
          3'd2: if (!wide && d[7:0] == 8'h83) mMode = 0;
          3'd3: begin
            mCtrl = d[7:0];
            if (d[7:0] == 8'h85) begin
              oRd = {mRd[1], mRd[0]}; oWr = {mWr[1], mWr[0]}; oSetup = mMisc[7:4];
            end
          end
          3'd6: mMisc = d[7:0];
          default: ;
        endcase
      end
      mKey = 0;
    end else if (unl) begin
      mMode = 1; mKey = 0;
    end else if (rd || wr) begin
      if (rd && wide && a == 3'd1) mKey = (mKey == 2) ? 2 : mKey + 1;
      else mKey = 0;
    end
  endtask

  task automatic idle(input string tag);
    op(0, 0, 0, 3'd0, 16'h0, tag);
  endtask

  task automatic key();
    op(1, 0, 1, 3'd1, 16'h0, "R2");
    op(1, 0, 1, 3'd1, 16'h0, "R2");
    op(0, 1, 0, 3'd2, 16'h0003, "R2");
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    resetModel();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    idle("R1");
    key();
    op(1, 0, 0, 3'd6, 16'h0, "R1");
    op(1, 0, 0, 3'd0, 16'h0, "R1");
    op(1, 0, 0, 3'd3, 16'h0, "R1");
    // R7: program both banks through the select bit
    op(0, 1, 0, 3'd6, 16'h0020, "R7");
    op(0, 1, 0, 3'd0, 16'h0046, "R7");
    op(0, 1, 0, 3'd1, 16'h0032, "R7");
    op(0, 1, 0, 3'd6, 16'h0011, "R7");
    op(0, 1, 1, 3'd0, 16'hAB59, "R7");
    op(0, 1, 0, 3'd1, 16'h0020, "R7");
    op(1, 0, 0, 3'd0, 16'h0, "R7");
    op(0, 1, 0, 3'd6, 16'h0020, "R7");
    op(1, 0, 0, 3'd0, 16'h0, "R7");
    op(1, 0, 1, 3'd1, 16'h0, "R7");
    // R6: strap live, ignored offsets, non-relock write to offset 2 (R8)
    strapClk25 = 1'b1;
    op(1, 0, 0, 3'd5, 16'h0, "R6");
    op(0, 1, 0, 3'd5, 16'h00FE, "R6");
    op(0, 1, 0, 3'd4, 16'h0077, "R6");
    op(0, 1, 1, 3'd2, 16'h0083, "R8");
    op(0, 1, 0, 3'd2, 16'h0003, "R8");
    op(1, 0, 0, 3'd4, 16'h0, "R6");
    op(1, 0, 0, 3'd7, 16'h0, "R6");
    // R9: non-commit control write holds outputs, then commit
    op(0, 1, 0, 3'd3, 16'h0084, "R9");
    idle("R9");
    op(0, 1, 0, 3'd3, 16'h0085, "R9");
    idle("R9");
    // R8: relock
    op(0, 1, 0, 3'd2, 16'h0083, "R8");
    idle("R8");
    // R3: broken key, then over-long key
    op(1, 0, 1, 3'd1, 16'h0, "R3");
    op(1, 0, 1, 3'd1, 16'h0, "R3");
    op(1, 0, 1, 3'd7, 16'h0, "R3");
    op(0, 1, 0, 3'd2, 16'h0003, "R3");
    op(1, 0, 1, 3'd1, 16'h0, "R3");
    op(1, 0, 0, 3'd1, 16'h0, "R3");
    op(1, 0, 1, 3'd1, 16'h0, "R3");
    op(0, 1, 0, 3'd2, 16'h0003, "R3");
    repeat (3) op(1, 0, 1, 3'd1, 16'h0, "R3");
    idle("R3");
    op(0, 1, 0, 3'd2, 16'h0003, "R3");
    idle("R3");
    op(0, 1, 0, 3'd2, 16'h0083, "R8");
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 99);
      bit [15:0] d;
      case ($urandom_range(0, 3))
        0: d = 16'h0003;
        1: d = 16'h0083;
        2: d = 16'h0085;
        default: d = 16'($urandom);
      endcase
      if ((i % 97) == 0) strapClk25 = ~strapClk25;
      if (sel < 6) key();
      else if (sel < 12) op(1, 0, 1, 3'd1, 16'h0, "R3");
      else if (sel < 20) idle("R4");
      else if (sel < 55) op(1, 0, 1'($urandom), 3'($urandom), d, "R4");
      else op(0, 1, 1'($urandom), 3'($urandom), d, "R4");
    end
    idle("R9");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule